// File: doc/BRIEF.md
# External interrupt pin router

This block lets software attach any of a wide vector of general-purpose input pins to a small set of external interrupt lines. Each line has one configuration register. The register chooses a pin, chooses whether a falling or a rising edge counts, and turns the line on or off. It also holds a status flag that only software can clear.

The pin space is split into a lower half and an upper half. The non-maskable line and maskable lines 1 and 2 can only reach the lower half. Lines 3 to 7 can only reach the upper half. A select value that points outside a line's half is folded back into that half. The line keeps the low bits of the value and adds the half's base.

Pins are sampled on the system clock through a two-stage synchronizer, with no qualification window. Each qualifying edge on the chosen pin gives a one-cycle pulse toward the interrupt expansion controller. Line 0 drives the non-maskable request instead.

Top module: `extint_router`

## Requirements
- R1: After reset, every register reads back with its select field equal to its group base (0 for lines 0 to 2, 32 for lines 3 to 7). Polarity (bit 8), enable (bit 9) and flag (bit 15) read 0, and all outputs are low.
- R2: A write to register `reg_addr_i` stores polarity from bit 8 and enable from bit 9. Reading that address on `rd_addr_i` returns the stored values in the same bit positions in the cycle after the write.
- R3: The select field occupies bits 5:0. Lines 0 to 2 store bits 4:0 of the written value with bit 5 forced to 0. Lines 3 to 7 store bits 4:0 with bit 5 forced to 1. The readback shows the pin actually used.
- R4: Pin inputs pass through two synchronizing flops. A qualifying pin change that is driven between clock edges raises its output after the third rising clock edge that follows.
- R5: With polarity 0 only a high-to-low transition of the chosen pin qualifies. With polarity 1 only a low-to-high transition qualifies. The opposite transition, or no transition, gives no pulse and no flag.
- R6: Each qualifying edge gives a pulse exactly one clock wide. A line with enable 0 gives neither a pulse nor a flag.
- R7: A qualifying edge on an enabled line sets its flag (bit 15). The flag stays set until a write to that register with bit 15 at 1. A write with bit 15 at 0 leaves the flag unchanged.
- R8: Line 0 drives `nmi_o` and line k (1 to 7) drives `irq_o[k-1]`. Transitions on pins that a line has not selected produce no output and no flag on that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 64 | General-purpose pin levels, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Line index written |
| reg_wdata_i | input | 16 | Write data: select 5:0, polarity 8, enable 9, flag clear 15 |
| rd_addr_i | input | 3 | Line index read |
| rd_data_o | output | 16 | Register readback, combinational |
| irq_o | output | 7 | One-cycle request pulses of maskable lines 1 to 7 |
| nmi_o | output | 1 | One-cycle request pulse of the non-maskable line |

## Verification
The bench builds the block with its default parameters: 64 pins, eight lines, and the first three lines in the lower group. With these values both halves of the pin space are reachable. The bench drives the boundary pins 0, 31, 32 and 63, and writes select values that fall outside a line's half so that the folding is exercised. The table of vectors covers each polarity against each transition direction on lines of both groups, including a disabled line and a level that does not move. Directed cases then cover the readback after reset, flag persistence and clearing, and pins toggled next to the chosen one.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int REG_W    = 16;
   localparam int POL_BIT  = 8;
   localparam int EN_BIT   = 9;
   localparam int FLAG_BIT = 15;
   localparam int SEL_MAX  = 8;

   typedef struct packed {
      logic pol;
      logic en;
      logic clr;
   } line_ctl_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] cur_o,
   output logic [WIDTH-1:0] prev_o
);
   logic [WIDTH-1:0] meta_q, cur_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         cur_q  <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= raw_i;
         cur_q  <= meta_q;
         prev_q <= cur_q;
      end
   end

   assign cur_o  = cur_q;
   assign prev_o = prev_q;
endmodule

// File: rtl/extint_line.sv
module extint_line
   import extint_pkg::*;
#(
   parameter int PIN_COUNT  = 64,
   parameter bit HIGH_GROUP = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] cur_i,
   input  logic [PIN_COUNT-1:0] prev_i,
   input  logic                 we_i,
   input  logic [$clog2(PIN_COUNT)-2:0] wsel_i,
   input  line_ctl_t            wctl_i,
   output logic [REG_W-1:0]     rdata_o,
   output logic                 pulse_o
);
   localparam int SEL_W = $clog2(PIN_COUNT);
   localparam logic [SEL_W-1:0] BASE = {HIGH_GROUP, {(SEL_W-1){1'b0}}};

   logic [SEL_W-1:0] sel_q;
   logic             pol_q, en_q, flag_q, pulse_q;
   logic             pin_now, pin_old, hit;

   assign pin_now = cur_i[sel_q];
   assign pin_old = prev_i[sel_q];
   assign hit     = pol_q ? (pin_now & ~pin_old) : (~pin_now & pin_old);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= BASE;
         pol_q <= 1'b0;
         en_q  <= 1'b0;
      end else if (we_i) begin
         sel_q <= {HIGH_GROUP, wsel_i};
         pol_q <= wctl_i.pol;
         en_q  <= wctl_i.en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         pulse_q <= en_q & hit;
         if (en_q & hit)
            flag_q <= 1'b1;
         else if (we_i & wctl_i.clr)
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      rdata_o              = '0;
      rdata_o[SEL_W-1:0]   = sel_q;
      rdata_o[POL_BIT]     = pol_q;
      rdata_o[EN_BIT]      = en_q;
      rdata_o[FLAG_BIT]    = flag_q;
   end

   assign pulse_o = pulse_q;

   assert_sel_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[SEL_W-1] == HIGH_GROUP);

   assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !pulse_o);

   assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && $stable(sel_q)) |=> !pulse_o);

   assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(we_i && wctl_i.clr)) |=> flag_q);

   assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> flag_q);
endmodule

// File: rtl/extint_router.sv
module extint_router
   import extint_pkg::*;
#(
   parameter int PIN_COUNT       = 64,
   parameter int CHAN_COUNT      = 8,
   parameter int LOW_GROUP_CHANS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PIN_COUNT-1:0]          pins_i,
   input  logic                          reg_we_i,
   input  logic [$clog2(CHAN_COUNT)-1:0] reg_addr_i,
   input  logic [REG_W-1:0]              reg_wdata_i,
   input  logic [$clog2(CHAN_COUNT)-1:0] rd_addr_i,
   output logic [REG_W-1:0]              rd_data_o,
   output logic [CHAN_COUNT-2:0]         irq_o,
   output logic                          nmi_o
);
   localparam int SEL_W  = $clog2(PIN_COUNT);
   localparam int GRP_W  = SEL_W - 1;
   localparam int ADDR_W = $clog2(CHAN_COUNT);

   if (PIN_COUNT < 4 || (1 << SEL_W) != PIN_COUNT)
      $error("PIN_COUNT must be a power of two of at least 4");
   if (SEL_W > SEL_MAX)
      $error("select field would overlap the polarity bit");
   if (CHAN_COUNT < 2 || LOW_GROUP_CHANS < 1 || LOW_GROUP_CHANS > CHAN_COUNT)
      $error("channel counts out of range");

   logic [PIN_COUNT-1:0] cur, prev;
   logic [REG_W-1:0]     rdata [CHAN_COUNT];
   logic [CHAN_COUNT-1:0] pulse;
   line_ctl_t            wctl;
   logic                 unused_wbits;

   assign wctl.pol     = reg_wdata_i[POL_BIT];
   assign wctl.en      = reg_wdata_i[EN_BIT];
   assign wctl.clr     = reg_wdata_i[FLAG_BIT];
   assign unused_wbits = ^reg_wdata_i;

   extint_sync #(.WIDTH(PIN_COUNT)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pins_i),
      .cur_o  (cur),
      .prev_o (prev)
   );

   for (genvar c = 0; c < CHAN_COUNT; c++) begin : g_line
      extint_line #(
         .PIN_COUNT  (PIN_COUNT),
         .HIGH_GROUP (c >= LOW_GROUP_CHANS)
      ) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .cur_i   (cur),
         .prev_i  (prev),
         .we_i    (reg_we_i && (reg_addr_i == ADDR_W'(c))),
         .wsel_i  (reg_wdata_i[GRP_W-1:0]),
         .wctl_i  (wctl),
         .rdata_o (rdata[c]),
         .pulse_o (pulse[c])
      );
   end

   always_comb begin
      rd_data_o = '0;
      for (int c = 0; c < CHAN_COUNT; c++)
         if (rd_addr_i == ADDR_W'(c))
            rd_data_o = rdata[c];
   end

   assign nmi_o = pulse[0];
   assign irq_o = pulse[CHAN_COUNT-1:1];
endmodule

// File: tb/sim_extint_router.sv
`timescale 1ns/1ps
module sim_extint_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pins = '0;
   logic        we = 1'b0;
   logic [2:0]  waddr = '0;
   logic [15:0] wdata = '0;
   logic [2:0]  raddr = '0;
   logic [15:0] rdata;
   logic [6:0]  irq;
   logic        nmi;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   extint_router u0 (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we_i(we),
      .reg_addr_i(waddr), .reg_wdata_i(wdata), .rd_addr_i(raddr),
      .rd_data_o(rdata), .irq_o(irq), .nmi_o(nmi)
   );

   // ch(3) sel(6) pol en start end
   localparam logic [12:0] VECS [10] = '{
      {3'd1, 6'd5,  1'b0, 1'b1, 1'b1, 1'b0},
      {3'd1, 6'd5,  1'b0, 1'b1, 1'b0, 1'b1},
      {3'd2, 6'd40, 1'b1, 1'b1, 1'b0, 1'b1},
      {3'd3, 6'd2,  1'b1, 1'b1, 1'b0, 1'b1},
      {3'd7, 6'd63, 1'b0, 1'b1, 1'b1, 1'b0},
      {3'd0, 6'd31, 1'b1, 1'b1, 1'b0, 1'b1},
      {3'd5, 6'd10, 1'b1, 1'b0, 1'b0, 1'b1},
      {3'd4, 6'd32, 1'b0, 1'b1, 1'b1, 1'b0},
      {3'd6, 6'd17, 1'b0, 1'b1, 1'b1, 1'b1},
      {3'd0, 6'd0,  1'b0, 1'b1, 1'b1, 1'b0}
   };

   function automatic logic [7:0] outs();
      return {irq, nmi};
   endfunction

   function automatic int eff_pin(int ch, int sel);
      return (ch >= 3 ? 32 : 0) + (sel % 32);
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int ch, logic [15:0] d);
      @(negedge clk);
      we = 1'b1; waddr = 3'(ch); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int ch, output logic [15:0] d);
      raddr = 3'(ch);
      #1 d = rdata;
   endtask

   function automatic logic [15:0] cfg(bit clr, bit en, bit pol, int sel);
      logic [15:0] v = '0;
      v[15] = clr; v[9] = en; v[8] = pol; v[5:0] = 6'(sel);
      return v;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int c = 0; c < 8; c++) begin
         rd(c, r);
         check("R1 reset register", r, 16'(c >= 3 ? 32 : 0));
      end
      check("R1 outputs low", 16'(outs()), 16'h0);

      // table walk: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < 10; i++) begin
         int ch, sel, p;
         bit pol, en, st, en_lvl, expp;
         {ch, sel} = {29'(VECS[i][12:10]), 26'(VECS[i][9:4])};
         ch = int'(VECS[i][12:10]); sel = int'(VECS[i][9:4]);
         pol = VECS[i][3]; en = VECS[i][2]; st = VECS[i][1]; en_lvl = VECS[i][0];
         p = eff_pin(ch, sel);
         expp = en && (st != en_lvl) && (en_lvl == pol);
         @(negedge clk); pins[p] = st;
         repeat (5) @(negedge clk);
         wr(ch, cfg(1'b1, en, pol, sel));
         pins[p] = en_lvl;
         repeat (3) @(posedge clk);
         @(negedge clk);
         check("R4 R5 R8 pulse at third edge", 16'(outs()), expp ? 16'(8'h1 << ch) : 16'h0);
         @(negedge clk);
         check("R6 pulse one cycle", 16'(outs()), 16'h0);
         rd(ch, r);
         check("R7 flag after edge", 16'(r[15]), 16'(expp));
         check("R3 select folded", 16'(r[5:0]), 16'(p));
         wr(ch, cfg(1'b1, 1'b0, 1'b0, 0));
         pins = '0;
         repeat (5) @(negedge clk);
      end

      // R2 readback of polarity and enable
      wr(3, cfg(1'b0, 1'b1, 1'b1, 7));
      rd(3, r);
      check("R2 pol/en readback", 16'(r[9:8]), 16'h3);
      check("R3 high group select", 16'(r[5:0]), 16'd39);
      wr(3, cfg(1'b0, 1'b0, 1'b1, 7));
      rd(3, r);
      check("R2 enable cleared", 16'(r[9:8]), 16'h1);

      // R8 unselected pins ignored
      wr(1, cfg(1'b1, 1'b1, 1'b1, 3));
      @(negedge clk); pins[4] = 1'b1; pins[35] = 1'b1; pins[2] = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R8 neighbour pins quiet", 16'(outs()), 16'h0);
      end
      rd(1, r);
      check("R8 no flag from neighbours", 16'(r[15]), 16'h0);

      // R7 sticky flag and software clear
      @(negedge clk); pins[3] = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R7 pulse on line 1", 16'(outs()), 16'h2);
      repeat (10) @(negedge clk);
      rd(1, r);
      check("R7 flag persists", 16'(r[15]), 16'h1);
      wr(1, cfg(1'b0, 1'b1, 1'b1, 3));
      rd(1, r);
      check("R7 write without clear keeps flag", 16'(r[15]), 16'h1);
      wr(1, cfg(1'b1, 1'b1, 1'b1, 3));
      rd(1, r);
      check("R7 clear write drops flag", 16'(r[15]), 16'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule